// File: doc/BRIEF.md
# Conditional Download Sequencer

This block walks a byte-wide instruction store from address zero and hands each instruction it chooses to run to the register-write logic downstream. That logic sees a one-cycle strobe and the opcode. Whether an ordinary instruction runs depends on two things. The first is the active 5-bit condition. The second is a table of 31 tag bits, which condition opcodes embedded in the stream set or wipe.

The active condition is the register field `reg_cond` when that field is nonzero. Otherwise it is the value of the condition pins captured in the first clock after the hard reset is released. A download starts by itself after that reset, and again on a soft-reset request, but only when the captured pin value is nonzero. An explicit download request starts one regardless of that value. An upload request walks the store as a plain pass-through: every byte is strobed out and conditions have no effect.

Top module: `cond_dl_seq`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `exec_valid` and `mem_rd` are all 0.
- R2: In the first clock edge after `rst_n` rises, the pins `pin_cond` are captured. If the captured value is nonzero, `busy` and `mem_rd` are 1 after that edge and `mem_addr` is 0. If it is zero, the block stays idle.
- R3: The active condition is `reg_cond` when `reg_cond` is nonzero. Otherwise it is the captured pin value.
- R4: In a download, opcodes 0xB1 to 0xCF set tag 1 to 31 respectively (tag = opcode − 0xB0) and produce no strobe. Opcodes 0xAF and 0xD0 are ordinary instructions.
- R5: In a download, opcode 0xB0 clears all tags and produces no strobe.
- R6: In a download, an ordinary opcode is strobed in either of two cases: the active condition is 0, or no tag is set. Otherwise it is strobed only if the tag of the active condition is set. A skipped opcode produces no strobe.
- R7: Opcode 0xFF ends a download or upload. It produces no strobe, drops `busy` and raises `done` after the accepting edge. `done` holds until the next reset, start request or soft-reset request.
- R8: A byte is accepted on an edge where `busy` and `mem_rvalid` are both 1. The byte's strobe appears on `exec_valid`/`exec_op` for the cycle after that edge. `mem_addr` advances by one per accepted byte and holds while `mem_rvalid` is 0.
- R9: `start_dl`, `start_ul` and `soft_rst_req` have no effect while `busy` is 1.
- R10: In an upload, every byte except 0xFF is strobed unchanged, condition opcodes included, whatever the condition and the tags.
- R11: All tags are cleared when a download starts.
- R12: A soft-reset request while idle clears `done`. It starts a download only if the pin value captured at the last hard reset is nonzero, and later pin changes do not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst_req | input | 1 | Soft-reset request pulse |
| start_dl | input | 1 | Explicit download request |
| start_ul | input | 1 | Upload (pass-through) request |
| pin_cond | input | 5 | Condition pins, captured after hard reset |
| reg_cond | input | 5 | Condition register field, nonzero overrides pins |
| mem_rd | output | 1 | Read request to the instruction store |
| mem_addr | output | ADDR_W | Address of the byte requested |
| mem_rvalid | input | 1 | Store returns a valid byte this cycle |
| mem_rdata | input | 8 | Byte at `mem_addr` |
| exec_valid | output | 1 | One-cycle strobe for an executed instruction |
| exec_op | output | 8 | Opcode of the executed instruction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence reached its end opcode |

## Verification
The assertions assume three things of the store. `mem_rdata` is meaningful whenever `mem_rvalid` is high. `mem_rvalid` is only raised while `mem_rd` is high. Every instruction stream ends in 0xFF before the address counter wraps.

The bench acts as the store. It drives a byte only while the block is busy, inserts stall cycles with `mem_rvalid` low, and closes every stream with 0xFF. It may change `reg_cond` between bytes, and it holds `reg_cond` steady across each accepting edge.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  localparam int          COND_W    = 5;
  localparam int          NUM_TAGS  = (1 << COND_W) - 1;
  localparam logic [7:0]  OP_NULL   = 8'hB0;
  localparam logic [7:0]  OP_TAG_LO = 8'hB1;
  localparam logic [7:0]  OP_TAG_HI = 8'hCF;
  localparam logic [7:0]  OP_END    = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_DOWN, ST_UP} seq_st_e;

  function automatic logic is_tag_op(input logic [7:0] op);
    return (op >= OP_TAG_LO) && (op <= OP_TAG_HI);
  endfunction

  function automatic logic [COND_W-1:0] tag_of(input logic [7:0] op);
    logic [7:0] d;
    d = op - OP_NULL;
    return d[COND_W-1:0];
  endfunction
endpackage

// File: rtl/cdl_cond_src.sv
module cdl_cond_src #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_cond,
  input  logic [W-1:0] reg_cond,
  output logic [W-1:0] fn_cond,
  output logic [W-1:0] act_cond,
  output logic         first_cyc
);
  logic [W-1:0] pin_lat;
  logic         lat_done;
  logic         lat_en;

  always_comb begin
    lat_en    = !lat_done;
    first_cyc = !lat_done;
    fn_cond   = lat_done ? pin_lat : pin_cond;
    act_cond  = (reg_cond != '0) ? reg_cond : fn_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_lat  <= '0;
      lat_done <= 1'b0;
    end else if (lat_en) begin
      pin_lat  <= pin_cond;
      lat_done <= 1'b1;
    end
  end

  // R12: the captured pin value never moves after the capture cycle
  assert_latch_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lat_done |=> $stable(pin_lat));
endmodule

// File: rtl/cdl_tag_table.sv
module cdl_tag_table #(
  parameter int N  = 31,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] look_idx,
  output logic          any_tag,
  output logic          hit
);
  logic [N-1:0] tags;
  logic [N-1:0] tags_nxt;

  for (genvar g = 0; g < N; g++) begin : g_tag
    always_comb begin
      if (clr)                                   tags_nxt[g] = 1'b0;
      else if (set_en && set_idx == IW'(g + 1))  tags_nxt[g] = 1'b1;
      else                                       tags_nxt[g] = tags[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tags <= '0;
    else        tags <= tags_nxt;
  end

  always_comb begin
    any_tag = |tags;
    hit     = 1'b0;
    for (int i = 0; i < N; i++)
      if (look_idx == IW'(i + 1)) hit = tags[i];
  end

  // R5 / R11: a clear leaves no tag behind
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any_tag);
  // R4: a set marks its entry
  assert_set_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr && set_idx != '0) |=> any_tag);
endmodule

// File: rtl/cdl_engine.sv
module cdl_engine
  import cdl_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_go,
  input  logic              soft_req,
  input  logic              fn_nz,
  input  logic              start_dl,
  input  logic              start_ul,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  input  logic [COND_W-1:0] act_cond,
  input  logic              any_tag,
  input  logic              hit,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic              exec_valid,
  output logic [7:0]        exec_op,
  output logic              busy,
  output logic              done,
  output logic              tag_clr,
  output logic              tag_set,
  output logic [COND_W-1:0] tag_set_idx
);
  seq_st_e       st, st_nxt;
  logic [AW-1:0] addr_nxt;
  logic          done_nxt, fire, op_en;
  logic          idle, go_dl, go_ul, done_clr, acc, in_dl;
  logic          op_end, op_null, op_tag, gate_ok;

  always_comb begin
    idle     = (st == ST_IDLE);
    in_dl    = (st == ST_DOWN);
    go_dl    = idle && (auto_go || (soft_req && fn_nz) || start_dl);
    go_ul    = idle && !go_dl && start_ul;
    done_clr = idle && (auto_go || soft_req || start_dl || start_ul);
    acc      = !idle && mem_rvalid;
    op_end   = (mem_rdata == OP_END);
    op_null  = (mem_rdata == OP_NULL);
    op_tag   = is_tag_op(mem_rdata);
    gate_ok  = (act_cond == '0) || !any_tag || hit;

    if (in_dl) fire = acc && !op_end && !op_null && !op_tag && gate_ok;
    else       fire = acc && !op_end;
    op_en = fire;

    tag_clr     = go_dl || (acc && in_dl && op_null);
    tag_set     = acc && in_dl && op_tag;
    tag_set_idx = tag_of(mem_rdata);

    st_nxt = st;
    if (go_dl)              st_nxt = ST_DOWN;
    else if (go_ul)         st_nxt = ST_UP;
    else if (acc && op_end) st_nxt = ST_IDLE;

    if (go_dl || go_ul) addr_nxt = '0;
    else if (acc)       addr_nxt = mem_addr + AW'(1);
    else                addr_nxt = mem_addr;

    if (acc && op_end) done_nxt = 1'b1;
    else if (done_clr) done_nxt = 1'b0;
    else               done_nxt = done;

    mem_rd = !idle;
    busy   = !idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      mem_addr   <= '0;
      done       <= 1'b0;
      exec_valid <= 1'b0;
    end else begin
      st         <= st_nxt;
      mem_addr   <= addr_nxt;
      done       <= done_nxt;
      exec_valid <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     exec_op <= '0;
    else if (op_en) exec_op <= mem_rdata;
  end

  assert_strobe_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> $past(mem_rd && mem_rvalid));
  assert_stall_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> $stable(mem_addr));
  assert_done_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_end_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rvalid && mem_rdata == OP_END) |=> (done && !busy && !exec_valid));
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(mem_rvalid && mem_rdata == OP_END)) |=> (busy && !done));
endmodule

// File: rtl/cond_dl_seq.sv
module cond_dl_seq
  import cdl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_req,
  input  logic              start_dl,
  input  logic              start_ul,
  input  logic [COND_W-1:0] pin_cond,
  input  logic [COND_W-1:0] reg_cond,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              exec_valid,
  output logic [7:0]        exec_op,
  output logic              busy,
  output logic              done
);
  logic [COND_W-1:0] fn_cond, act_cond, tag_set_idx;
  logic              first_cyc, auto_go, fn_nz;
  logic              any_tag, hit, tag_clr, tag_set;

  assign fn_nz   = (fn_cond != '0);
  assign auto_go = first_cyc && fn_nz;

  cdl_cond_src #(.W(COND_W)) u_src (
    .clk(clk), .rst_n(rst_n), .pin_cond(pin_cond), .reg_cond(reg_cond),
    .fn_cond(fn_cond), .act_cond(act_cond), .first_cyc(first_cyc)
  );

  cdl_tag_table #(.N(NUM_TAGS), .IW(COND_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .clr(tag_clr), .set_en(tag_set),
    .set_idx(tag_set_idx), .look_idx(act_cond), .any_tag(any_tag), .hit(hit)
  );

  cdl_engine #(.AW(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .auto_go(auto_go), .soft_req(soft_rst_req),
    .fn_nz(fn_nz), .start_dl(start_dl), .start_ul(start_ul),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .act_cond(act_cond),
    .any_tag(any_tag), .hit(hit), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .exec_valid(exec_valid), .exec_op(exec_op), .busy(busy), .done(done),
    .tag_clr(tag_clr), .tag_set(tag_set), .tag_set_idx(tag_set_idx)
  );
endmodule

// File: tb/cond_dl_seq_bench.sv
module cond_dl_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // {reg_cond, opcode, strobe expected}; captured pins = 5
  localparam logic [13:0] VEC [0:NVEC-1] = '{
    {5'd0,  8'h10, 1'b1}, {5'd0,  8'hB3, 1'b0}, {5'd0,  8'h11, 1'b0},
    {5'd0,  8'hB5, 1'b0}, {5'd0,  8'h12, 1'b1}, {5'd3,  8'h13, 1'b1},
    {5'd7,  8'h14, 1'b0}, {5'd0,  8'hB0, 1'b0}, {5'd7,  8'h15, 1'b1},
    {5'd0,  8'hCF, 1'b0}, {5'd31, 8'h16, 1'b1}, {5'd0,  8'h17, 1'b0},
    {5'd0,  8'hB1, 1'b0}, {5'd1,  8'h18, 1'b1}, {5'd2,  8'hAF, 1'b0},
    {5'd0,  8'hD0, 1'b0}, {5'd0,  8'hFF, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n, soft_rst_req, start_dl, start_ul, mem_rvalid;
  logic [4:0] pin_cond, reg_cond;
  logic [7:0] mem_rdata, exec_op;
  logic [9:0] mem_addr;
  logic       mem_rd, exec_valid, busy, done;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cond_dl_seq u_cond_dl_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst_req(soft_rst_req), .start_dl(start_dl),
    .start_ul(start_ul), .pin_cond(pin_cond), .reg_cond(reg_cond),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .exec_valid(exec_valid), .exec_op(exec_op),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic feed(input logic [7:0] op, input logic [4:0] rc, input logic exp, input string req);
    mem_rvalid = 1'b1; mem_rdata = op; reg_cond = rc;
    tick;
    mem_rvalid = 1'b0;
    chk(req, "exec_valid", int'(exec_valid), int'(exp));
    if (exp) chk(req, "exec_op", int'(exec_op), int'(op));
  endtask

  task automatic pulse(input int which);
    soft_rst_req = (which == 0); start_dl = (which == 1); start_ul = (which == 2);
    tick;
    soft_rst_req = 1'b0; start_dl = 1'b0; start_ul = 1'b0;
  endtask

  task automatic do_reset(input logic [4:0] pins);
    @(negedge clk);
    rst_n = 1'b0; pin_cond = pins; reg_cond = '0; mem_rvalid = 1'b0; mem_rdata = '0;
    soft_rst_req = 1'b0; start_dl = 1'b0; start_ul = 1'b0;
    tick; tick;
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "exec_valid in reset", int'(exec_valid), 0);
    chk("R1", "mem_rd in reset", int'(mem_rd), 0);
    rst_n = 1'b1;
    tick;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    // R2: zero pins, no automatic start
    do_reset(5'd0);
    chk("R2", "busy, zero pins", int'(busy), 0);
    tick;
    chk("R2", "still idle", int'(busy), 0);

    // R2: nonzero pins start a download
    do_reset(5'd5);
    chk("R2", "busy after auto start", int'(busy), 1);
    chk("R2", "mem_rd after auto start", int'(mem_rd), 1);
    chk("R2", "mem_addr at start", int'(mem_addr), 0);
    pin_cond = 5'd0; // R12: later pin changes must not matter

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      if (i % 3 == 1) begin
        tick; // stall with mem_rvalid low
        chk("R8", "no strobe on stall", int'(exec_valid), 0);
        chk("R8", "addr held on stall", int'(mem_addr), i);
      end
      chk("R8", "mem_addr", int'(mem_addr), i);
      feed(VEC[i][8:1], VEC[i][13:9], VEC[i][0], "R6");
    end
    chk("R7", "done after end", int'(done), 1);
    chk("R7", "busy after end", int'(busy), 0);
    tick; tick; tick;
    chk("R7", "done holds", int'(done), 1);

    // R11: new download clears tags; R9 start while busy
    pulse(1);
    chk("R7", "done cleared by start", int'(done), 0);
    chk("R11", "busy", int'(busy), 1);
    feed(8'h30, 5'd0, 1'b1, "R11");
    pulse(2);
    chk("R9", "busy after upload req", int'(busy), 1);
    feed(8'hB2, 5'd0, 1'b0, "R9");
    feed(8'h31, 5'd0, 1'b0, "R6");
    feed(8'hFF, 5'd0, 1'b0, "R7");
    chk("R7", "done", int'(done), 1);

    // R10 upload pass-through
    pulse(2);
    chk("R10", "busy in upload", int'(busy), 1);
    feed(8'hB5, 5'd0, 1'b1, "R10");
    feed(8'h40, 5'd9, 1'b1, "R10");
    feed(8'hB0, 5'd0, 1'b1, "R10");
    feed(8'hFF, 5'd0, 1'b0, "R10");
    chk("R7", "done after upload", int'(done), 1);

    // R12 soft reset uses captured pins (5) though pins now 0
    pulse(0);
    chk("R12", "busy after soft reset", int'(busy), 1);
    chk("R12", "done cleared", int'(done), 0);
    feed(8'hFF, 5'd0, 1'b0, "R12");

    // R12 captured zero: soft reset only clears done
    do_reset(5'd0);
    pulse(0);
    chk("R12", "no start, zero capture", int'(busy), 0);

    // R6 null condition
    pulse(1);
    chk("R6", "busy on explicit start", int'(busy), 1);
    feed(8'hB4, 5'd0, 1'b0, "R4");
    feed(8'h20, 5'd0, 1'b1, "R6");
    feed(8'h21, 5'd4, 1'b1, "R3");
    feed(8'h22, 5'd9, 1'b0, "R3");
    feed(8'hFF, 5'd0, 1'b0, "R7");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule